// File: doc/BRIEF.md
# Eight-Character Display Register Buffer

This block keeps the text of a small eight-character display in eight byte-wide cells. A simple register bus reaches those cells through a 3-bit byte address, a byte count of 1, 2, 4 or 8, a 64-bit write word and a 64-bit read word. A multi-byte access wraps inside the 8-byte window. Each write triggers a refresh of the whole display. The refresh goes out as a byte stream over a valid/ready handshake: a carriage return, then all eight cells in a fixed-width field.

The character stream waits until the consumer raises `chan_open`. It then sends a single blank line of eight spaces, which is never repeated. After that it sends only refresh frames.

The refresh logic is a five-state machine:
- `ST_WAIT_OPEN`: the state after reset.
- `ST_BLANK`: the eight spaces go out.
- `ST_IDLE`: nothing is sent.
- `ST_CR`: the carriage return is offered.
- `ST_CHAR`: the cells are offered one by one.

Its transitions:
- WAIT_OPEN→BLANK when the channel opens.
- BLANK→IDLE after the eighth space.
- BLANK→CR after the eighth space if a write came before the channel opened.
- BLANK→CR when a write arrives (abort).
- IDLE→CR on a write.
- CR→CHAR on acceptance.
- CR→CR on a write.
- CHAR→IDLE after cell 7 is accepted.
- CHAR→CR on a write (abort and restart).

Top module: `disp_buffer`

## Requirements
- R1: After reset every cell holds 0x00, so an 8-byte read at any address returns 0.
- R2: A write of N bytes (N = 1, 2, 4 or 8) at address A stores data bits [8k+7:8k] into cell (A+k) mod 8 for k = 0..N-1, and leaves the other cells unchanged.
- R3: A read of N bytes at address A returns cell (A+k) mod 8 in bits [8k+7:8k] for k < N, and zero in every byte lane k >= N. The read data is combinational.
- R4: Any size value other than 1, 2, 4 or 8 acts as a 1-byte access, for both reads and writes.
- R5: Before `chan_open` has first been seen high, `tx_valid` stays low. The first time it is seen high, eight bytes of 0x20 are sent. This blank line is never sent again, even if `chan_open` toggles.
- R6: After a write (channel already open), the stream sends exactly 0x0D followed by cells 0 to 7 in order, then goes idle.
- R7: A cell holding 0x00 is sent as 0x20. No byte with value 0x00 is ever presented.
- R8: A write during a frame drops the frame in progress. The byte offered in the next cycle is 0x0D, and a complete fresh frame follows. The bus has no stall signal.
- R9: While `tx_valid` is high and `tx_ready` is low, and no write occurs, `tx_valid` and `tx_data` hold their values.
- R10: A write made before the channel opens is stored. Once the channel opens, the blank line is sent first and then one refresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 3 | Byte address of the first cell |
| size | input | 4 | Access size in bytes (1, 2, 4, 8; others act as 1) |
| wdata | input | 64 | Write data, little-endian byte lanes |
| rdata | output | 64 | Read data for addr/size, combinational |
| chan_open | input | 1 | Consumer channel available |
| tx_ready | input | 1 | Consumer accepts the offered byte |
| tx_valid | output | 1 | A stream byte is offered |
| tx_data | output | 8 | Offered stream byte |

## Verification
The checker watches several rules on every cycle:
- The stream stays silent before the channel opens.
- No 0x00 byte ever appears on the stream.
- An unaccepted byte is held until accepted.
- A write always puts a carriage return on the stream in the following cycle.
- Read lanes above the normalised size are zero.

Only the bench scenarios can show the rest. These are the exact byte order of a frame, the wrapped cell mapping for writes and reads, the one-time blank line, the deferred frame after a write made before the channel opened, and a clean full frame after an abort under random backpressure.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_SPACE = 8'h20;

    typedef enum logic [2:0] {
        ST_WAIT_OPEN = 3'd0,
        ST_BLANK     = 3'd1,
        ST_IDLE      = 3'd2,
        ST_CR        = 3'd3,
        ST_CHAR      = 3'd4
    } stream_state_e;

    // Byte count of an access; unsupported codes fall back to one byte.
    function automatic logic [3:0] norm_size(input logic [3:0] raw);
        logic [3:0] n;
        unique case (raw)
            4'd1, 4'd2, 4'd4, 4'd8: n = raw;
            default:                n = 4'd1;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/disp_cells.sv
module disp_cells #(
    parameter int CELLS = 8,
    parameter int LANES = 8,
    localparam int AW   = $clog2(CELLS),
    localparam int BW   = LANES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [3:0]         size,
    input  logic [BW-1:0]      wdata,
    output logic [BW-1:0]      rdata,
    output logic [CELLS*8-1:0] cells_flat
);
    import disp_pkg::*;

    logic [7:0] cell_q [CELLS];
    logic [3:0] nbytes;

    assign nbytes = norm_size(size);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CELLS; c++) cell_q[c] <= 8'h00;
        end else if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (k < int'(nbytes))
                    cell_q[AW'(int'(addr) + k)] <= wdata[k*8 +: 8];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < LANES; k++) begin
            if (k < int'(nbytes))
                rdata[k*8 +: 8] = cell_q[AW'(int'(addr) + k)];
        end
    end

    for (genvar g = 0; g < CELLS; g++) begin : g_flat
        assign cells_flat[g*8 +: 8] = cell_q[g];
    end

endmodule

// File: rtl/disp_stream.sv
module disp_stream #(
    parameter int CELLS = 8,
    localparam int IW   = $clog2(CELLS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               chan_open,
    input  logic [CELLS*8-1:0] cells_flat,
    input  logic               tx_ready,
    output logic               tx_valid,
    output logic [7:0]         tx_data
);
    import disp_pkg::*;

    localparam logic [IW-1:0] LAST = IW'(CELLS - 1);

    stream_state_e st_q, st_n;
    logic [IW-1:0] idx_q, idx_n;
    logic          pend_q, pend_n;
    logic [7:0]    cur_cell;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_WAIT_OPEN;
            idx_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            idx_q  <= idx_n;
            pend_q <= pend_n;
        end
    end

    // Next state
    always_comb begin
        st_n   = st_q;
        idx_n  = idx_q;
        pend_n = pend_q;
        unique case (st_q)
            ST_WAIT_OPEN: begin
                if (wr_en) pend_n = 1'b1;
                if (chan_open) begin
                    st_n  = ST_BLANK;
                    idx_n = '0;
                end
            end
            ST_BLANK: begin
                if (wr_en) begin
                    st_n   = ST_CR;
                    pend_n = 1'b0;
                end else if (tx_ready) begin
                    if (idx_q == LAST) begin
                        st_n   = pend_q ? ST_CR : ST_IDLE;
                        pend_n = 1'b0;
                    end else begin
                        idx_n = idx_q + 1'b1;
                    end
                end
            end
            ST_IDLE: begin
                if (wr_en) st_n = ST_CR;
            end
            ST_CR: begin
                if (wr_en) begin
                    st_n = ST_CR;
                end else if (tx_ready) begin
                    st_n  = ST_CHAR;
                    idx_n = '0;
                end
            end
            ST_CHAR: begin
                if (wr_en) begin
                    st_n = ST_CR;
                end else if (tx_ready) begin
                    if (idx_q == LAST) st_n = ST_IDLE;
                    else               idx_n = idx_q + 1'b1;
                end
            end
            default: st_n = ST_WAIT_OPEN;
        endcase
    end

    assign cur_cell = cells_flat[idx_q*8 +: 8];

    // Outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = CH_SPACE;
        unique case (st_q)
            ST_BLANK: begin
                tx_valid = 1'b1;
                tx_data  = CH_SPACE;
            end
            ST_CR: begin
                tx_valid = 1'b1;
                tx_data  = CH_CR;
            end
            ST_CHAR: begin
                tx_valid = 1'b1;
                tx_data  = (cur_cell == 8'h00) ? CH_SPACE : cur_cell;
            end
            default: begin
                tx_valid = 1'b0;
                tx_data  = CH_SPACE;
            end
        endcase
    end

endmodule

// File: rtl/disp_buffer.sv
module disp_buffer #(
    parameter int CELLS     = 8,
    parameter int BUS_BYTES = 8,
    localparam int AW       = $clog2(CELLS),
    localparam int BW       = BUS_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [3:0]    size,
    input  logic [BW-1:0] wdata,
    output logic [BW-1:0] rdata,
    input  logic          chan_open,
    input  logic          tx_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_data
);

    logic [CELLS*8-1:0] cells_flat;

    disp_cells #(
        .CELLS (CELLS),
        .LANES (BUS_BYTES)
    ) u_cells (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .size       (size),
        .wdata      (wdata),
        .rdata      (rdata),
        .cells_flat (cells_flat)
    );

    disp_stream #(
        .CELLS (CELLS)
    ) u_stream (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .chan_open  (chan_open),
        .cells_flat (cells_flat),
        .tx_ready   (tx_ready),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data)
    );

endmodule

// File: rtl/disp_buffer_chk.sv
module disp_buffer_chk #(
    parameter int AW = 3,
    parameter int BW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [3:0]    size,
    input logic [BW-1:0] rdata,
    input logic          chan_open,
    input logic          tx_ready,
    input logic          tx_valid,
    input logic [7:0]    tx_data
);
    logic opened_q;

    always_ff @(posedge clk) begin
        if (!rst_n)         opened_q <= 1'b0;
        else if (chan_open) opened_q <= 1'b1;
    end

    AST_SILENT_BEFORE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !opened_q |-> !tx_valid);                                         // R5

    AST_NO_ZERO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_data != 8'h00);                                   // R7

    AST_WRITE_STARTS_CR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && opened_q) |=> (tx_valid && tx_data == 8'h0D));          // R8

    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !wr_en) |=> (tx_valid && $stable(tx_data))); // R9

    AST_READ_LANES_2: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 4'd2) |-> rdata[BW-1:16] == '0);                         // R3

    AST_READ_LANES_4: assert property (@(posedge clk) disable iff (!rst_n)
        (size == 4'd4) |-> rdata[BW-1:32] == '0);                         // R3

    AST_READ_LANES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (size != 4'd2 && size != 4'd4 && size != 4'd8) |-> rdata[BW-1:8] == '0); // R4

endmodule

bind disp_buffer disp_buffer_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .size      (size),
    .rdata     (rdata),
    .chan_open (chan_open),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data)
);

// File: tb/disp_buffer_bench.sv
module disp_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  addr;
    logic [3:0]  size;
    logic [63:0] wdata;
    logic [63:0] rdata;
    logic        chan_open;
    logic        tx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;

    always #2 clk = ~clk;   // 250 MHz

    disp_buffer u_disp_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .size      (size),
        .wdata     (wdata),
        .rdata     (rdata),
        .chan_open (chan_open),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data)
    );

    int checks   = 0;
    int failures = 0;
    logic [7:0] mdl [8];
    logic [7:0] cap [4096];
    int cap_n = 0;

    // Stream monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            cap[cap_n % 4096] = tx_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] eff_size(input logic [3:0] s);
        return (s == 1 || s == 2 || s == 4 || s == 8) ? s : 4'd1;
    endfunction

    function automatic logic [63:0] exp_read(input logic [2:0] a, input logic [3:0] s);
        logic [63:0] v = '0;
        for (int k = 0; k < 8; k++)
            if (k < int'(eff_size(s))) v[k*8 +: 8] = mdl[3'(int'(a) + k)];
        return v;
    endfunction

    function automatic logic [7:0] shown(input logic [7:0] c);
        return (c == 8'h00) ? 8'h20 : c;
    endfunction

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; wr_en = 0; addr = 0; size = 1; wdata = 0;
        chan_open = 0; tx_ready = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int c = 0; c < 8; c++) mdl[c] = 8'h00;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [3:0] s, input logic [63:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; size = s; wdata = d;
        for (int k = 0; k < 8; k++)
            if (k < int'(eff_size(s))) mdl[3'(int'(a) + k)] = d[k*8 +: 8];
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic do_read(input logic [2:0] a, input logic [3:0] s, input string req);
        @(posedge clk); #1;
        addr = a; size = s;
        @(negedge clk);
        chk(rdata == exp_read(a, s), req, rdata, exp_read(a, s));
    endtask

    task automatic wait_bytes(input int target, input bit rnd_ready);
        for (int t = 0; t < 400 && cap_n < target; t++) begin
            @(posedge clk); #1;
            tx_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
        end
        @(posedge clk); #1 tx_ready = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    // Checks the 9 bytes starting at position p against CR + model
    task automatic chk_frame(input int p, input string req);
        chk(cap[p % 4096] == 8'h0D, req, 64'(cap[p % 4096]), 64'h0D);
        for (int c = 0; c < 8; c++)
            chk(cap[(p + 1 + c) % 4096] == shown(mdl[c]), req,
                64'(cap[(p + 1 + c) % 4096]), 64'(shown(mdl[c])));
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        logic [3:0] sizes [6];
        sizes[0] = 1; sizes[1] = 2; sizes[2] = 4; sizes[3] = 8; sizes[4] = 3; sizes[5] = 0;
        void'($urandom(32'h5EED_0042));

        do_reset();
        // R1: reset contents
        do_read(3'd0, 4'd8, "R1");
        do_read(3'd5, 4'd8, "R1");

        // R5: silent before the channel opens
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(tx_valid == 1'b0 && cap_n == 0, "R5", 64'(tx_valid), 64'h0);
        base = cap_n;
        @(posedge clk); #1 chan_open = 1;
        wait_bytes(base + 8, 1'b0);
        repeat (10) @(posedge clk);
        chk(cap_n == base + 8, "R5", 64'(cap_n - base), 64'd8);
        for (int c = 0; c < 8; c++)
            chk(cap[(base + c) % 4096] == 8'h20, "R5", 64'(cap[(base + c) % 4096]), 64'h20);
        @(posedge clk); #1 chan_open = 0;
        repeat (3) @(posedge clk); #1 chan_open = 1;
        repeat (12) @(posedge clk);
        chk(cap_n == base + 8, "R5", 64'(cap_n - base), 64'd8);

        // R2 R6 R7: wrapped 4-byte write, frame contents with spaces for empty cells
        base = cap_n;
        do_write(3'd6, 4'd4, 64'h0000_0000_4443_4241);
        wait_bytes(base + 9, 1'b0);
        chk(cap_n == base + 9, "R6", 64'(cap_n - base), 64'd9);
        chk_frame(base, "R6");
        chk(cap[(base + 3) % 4096] == 8'h20, "R7", 64'(cap[(base + 3) % 4096]), 64'h20);
        @(negedge clk);
        chk(tx_valid == 1'b0, "R6", 64'(tx_valid), 64'h0);
        do_read(3'd6, 4'd4, "R2");
        do_read(3'd7, 4'd2, "R3");

        // R4: unsupported size acts as one byte
        base = cap_n;
        do_write(3'd2, 4'd3, 64'hFFFF_FFFF_FFFF_FF51);
        wait_bytes(base + 9, 1'b0);
        do_read(3'd3, 4'd1, "R4");
        do_read(3'd2, 4'd5, "R4");
        chk(mdl[3] == 8'h00, "R4", 64'(mdl[3]), 64'h0);

        // R9: byte held under backpressure
        @(posedge clk); #1 tx_ready = 0;
        base = cap_n;
        do_write(3'd0, 4'd8, 64'h4847_4645_4443_4241);
        #1 tx_ready = 0;
        repeat (3) begin
            @(negedge clk);
            chk(tx_valid && tx_data == 8'h0D, "R9", 64'(tx_data), 64'h0D);
        end
        wait_bytes(base + 9, 1'b0);
        chk_frame(base, "R9");

        // R8: write during a frame aborts it
        base = cap_n;
        do_write(3'd1, 4'd1, 64'h5A);
        repeat (2) @(posedge clk);
        do_write(3'd4, 4'd2, 64'h7978);
        wait_bytes(base + 30, 1'b0);
        chk(cap_n - base < 18 && cap_n - base > 9, "R8", 64'(cap_n - base), 64'd12);
        chk_frame(cap_n - 9, "R8");

        // Random mix under random backpressure
        for (int it = 0; it < 40; it++) begin
            logic [2:0]  ra = 3'($urandom);
            logic [3:0]  rs = sizes[$urandom % 6];
            logic [63:0] rd = {$urandom, $urandom};
            base = cap_n;
            do_write(ra, rs, rd);
            wait_bytes(base + 9, 1'b1);
            chk(cap_n == base + 9, "R6", 64'(cap_n - base), 64'd9);
            chk_frame(base, "R2");
            do_read(3'($urandom), sizes[$urandom % 6], "R3");
        end

        // R10: write before the channel opens
        do_reset();
        base = cap_n;
        do_write(3'd6, 4'd4, 64'h0000_0000_4443_4241);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(cap_n == base, "R10", 64'(cap_n - base), 64'd0);
        @(posedge clk); #1 chan_open = 1;
        wait_bytes(base + 17, 1'b0);
        chk(cap_n == base + 17, "R10", 64'(cap_n - base), 64'd17);
        for (int c = 0; c < 8; c++)
            chk(cap[(base + c) % 4096] == 8'h20, "R10", 64'(cap[(base + c) % 4096]), 64'h20);
        chk_frame(base + 8, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule